// File: doc/BRIEF.md
# Counter Channel with Reload, Match and Capture

This block is a single up/down counter channel driven by a count-enable and a direction input. Its count can be reloaded from a stored start value in three ways: by a software command, by a rising edge on a control input, or automatically when the count runs past either end of its range. A compare value is watched continuously. When the count arrives at that value, a sticky match flag is set, and the flag can also drive an interrupt line.

The channel can also capture the count. A capture copies the count into a snapshot that stays frozen until software either reads it or explicitly releases it. If a capture arrives while the snapshot is frozen, that capture is lost and a sticky overflow flag is set.

Software reaches the channel through a plain 32-bit register bus with byte enables. Only full-word accesses have any effect. The counter width is a parameter, up to 32 bits.

The hold logic is a two-state machine:
- `HOLD_IDLE` moves to `HOLD_BUSY` on a capture (transition *capture*).
- `HOLD_BUSY` returns to `HOLD_IDLE` on a full-word read of the snapshot or a release write (transition *release*).
- A capture while in `HOLD_BUSY` keeps the state (transition *lost capture*).

Each cycle the counter selects one step kind: `STEP_IDLE`, `STEP_LOAD`, `STEP_INC`, `STEP_DEC` or `STEP_RELOAD`.

Top module: `counter_channel`

## Requirements
- R1: Register map. Offset 0x120 holds the start value (read/write). Offset 0x124 holds the compare value (read/write). Offset 0x128 holds the snapshot (read-only). Offset 0x12C holds the mode word (read/write): bits [1:0] select free-run = 0, load-on-control = 1, divide-by-N = 2, capture-on-control = 3, and bit 3 enables the interrupt. Offset 0x130 takes commands: bit 4 = load, bit 6 = capture; it reads as 0. Offset 0x134 is status: bit 2 = match, bit 5 = hold active, bit 6 = overflow. Unmapped offsets read 0. Values of fewer than 32 bits read zero-extended.
- R2: After reset the start value, count, snapshot, mode and status are 0, the compare value is all ones in the counter width, and `irq` is 0.
- R3: Outside divide-by-N, a cycle with `cnt_en` high adds 1 (`count_up` = 1) or subtracts 1 (`count_up` = 0), wrapping modulo 2^CW. With `cnt_en` low the count holds.
- R4: A full-word command write with bit 4 set loads the start value into the count, visible from the next cycle. The load wins over counting in the same cycle.
- R5: In load-on-control mode, a rising edge on `ctl_in` loads the start value. In any other mode the edge does not load.
- R6: In divide-by-N mode, counting up from all ones or down from 0 puts the start value into the count in that same cycle, instead of the wrapped value.
- R7: The match flag is set when the count takes a new value (by a step or a load) equal to the compare value. It is not set again while the count stays equal. It stays set until a status write with bit 2 = 1, and a new match in the same cycle as that write wins.
- R8: `irq` is high exactly when the match flag and mode bit 3 are both 1.
- R9: A capture (command bit 6, or a rising `ctl_in` edge in capture-on-control mode) copies the current count into the snapshot and sets hold active. Snapshot reads return the frozen value while hold is active and the live count otherwise.
- R10: Hold ends on a full-word read of offset 0x128 or on a status write with bit 5 = 1.
- R11: A capture while hold is active leaves the snapshot unchanged and sets the overflow flag. The flag is cleared by a status write with bit 6 = 1.
- R12: An access whose byte enables are not all ones has no effect. A partial write changes no register. A partial read returns 0 and does not end hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_be | input | 4 | Byte enables; only 4'hF is honoured |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on the access cycle |
| cnt_en | input | 1 | Count enable |
| count_up | input | 1 | Direction, 1 = up |
| ctl_in | input | 1 | Control input, rising edge is the event |
| irq | output | 1 | Match interrupt |

## Verification
The assertions assume a few things about the inputs:
- Inputs are synchronous to `clk` and stable around the rising edge.
- A bus access lasts exactly one cycle.
- Load and capture commands are only issued as full-word writes.

The bench drives every input at the falling edge and holds each access for one cycle. It reaches the control input only through single-cycle pulses separated by a low cycle, so each pulse yields exactly one edge. The counter is built 8 bits wide so that wrap, carry and borrow are reached in short runs, and expected counts are computed from the start value and the step count.

// File: rtl/cntch_pkg.sv
package cntch_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 12;
    localparam int BE_W   = BUS_W / 8;

    localparam logic [ADDR_W-1:0] OFS_START = 12'h120;
    localparam logic [ADDR_W-1:0] OFS_CMP   = 12'h124;
    localparam logic [ADDR_W-1:0] OFS_SNAP  = 12'h128;
    localparam logic [ADDR_W-1:0] OFS_MODE  = 12'h12C;
    localparam logic [ADDR_W-1:0] OFS_CMD   = 12'h130;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 12'h134;

    localparam int CMD_LOAD_BIT  = 4;
    localparam int CMD_CAP_BIT   = 6;
    localparam int ST_MATCH_BIT  = 2;
    localparam int ST_HOLD_BIT   = 5;
    localparam int ST_OVFL_BIT   = 6;
    localparam int MODE_IE_BIT   = 3;

    typedef enum logic [1:0] {
        MODE_FREE    = 2'd0,
        MODE_LOADCTL = 2'd1,
        MODE_DIVN    = 2'd2,
        MODE_CAPCTL  = 2'd3
    } mode_e;

    typedef enum logic {
        HOLD_IDLE = 1'b0,
        HOLD_BUSY = 1'b1
    } hold_e;

    typedef enum logic [2:0] {
        STEP_IDLE   = 3'd0,
        STEP_LOAD   = 3'd1,
        STEP_INC    = 3'd2,
        STEP_DEC    = 3'd3,
        STEP_RELOAD = 3'd4
    } step_e;

endpackage

// File: rtl/cntch_regs.sv
module cntch_regs
    import cntch_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [CW-1:0]     cnt_val,
    input  logic [CW-1:0]     snap_val,
    input  logic              held,
    input  logic              mat,
    input  logic              ovfl,
    output logic [CW-1:0]     start_q,
    output logic [CW-1:0]     cmp_q,
    output mode_e             mode_q,
    output logic              ie_q,
    output logic              cmd_load,
    output logic              cmd_cap,
    output logic              clr_mat,
    output logic              clr_ovfl,
    output logic              rel_req
);

    localparam logic [BE_W-1:0] FULL_BE = '1;

    logic wr_ok;
    logic rd_ok;
    logic rel_read;
    logic rel_write;

    assign wr_ok = bus_en && bus_wr && (bus_be == FULL_BE);
    assign rd_ok = bus_en && !bus_wr && (bus_be == FULL_BE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            cmp_q   <= '1;
            mode_q  <= MODE_FREE;
            ie_q    <= 1'b0;
        end else if (wr_ok) begin
            if (bus_addr == OFS_START) start_q <= bus_wdata[CW-1:0];
            if (bus_addr == OFS_CMP)   cmp_q   <= bus_wdata[CW-1:0];
            if (bus_addr == OFS_MODE) begin
                mode_q <= mode_e'(bus_wdata[1:0]);
                ie_q   <= bus_wdata[MODE_IE_BIT];
            end
        end
    end

    always_comb begin
        cmd_load  = wr_ok && (bus_addr == OFS_CMD)  && bus_wdata[CMD_LOAD_BIT];
        cmd_cap   = wr_ok && (bus_addr == OFS_CMD)  && bus_wdata[CMD_CAP_BIT];
        clr_mat   = wr_ok && (bus_addr == OFS_STAT) && bus_wdata[ST_MATCH_BIT];
        clr_ovfl  = wr_ok && (bus_addr == OFS_STAT) && bus_wdata[ST_OVFL_BIT];
        rel_write = wr_ok && (bus_addr == OFS_STAT) && bus_wdata[ST_HOLD_BIT];
        rel_read  = rd_ok && (bus_addr == OFS_SNAP);
        rel_req   = rel_write || rel_read;
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_ok) begin
            case (bus_addr)
                OFS_START: bus_rdata = BUS_W'(start_q);
                OFS_CMP:   bus_rdata = BUS_W'(cmp_q);
                OFS_SNAP:  bus_rdata = held ? BUS_W'(snap_val) : BUS_W'(cnt_val);
                OFS_MODE: begin
                    bus_rdata[1:0]         = mode_q;
                    bus_rdata[MODE_IE_BIT] = ie_q;
                end
                OFS_STAT: begin
                    bus_rdata[ST_MATCH_BIT] = mat;
                    bus_rdata[ST_HOLD_BIT]  = held;
                    bus_rdata[ST_OVFL_BIT]  = ovfl;
                end
                default:   bus_rdata = '0;
            endcase
        end
    end

    // R12: a write with partial byte enables leaves the stored registers unchanged
    a_r12_partial_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_wr && (bus_be != FULL_BE))
        |=> ($stable(start_q) && $stable(cmp_q) && $stable(mode_q) && $stable(ie_q)));

endmodule

// File: rtl/cntch_core.sv
module cntch_core
    import cntch_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_en,
    input  logic          count_up,
    input  logic          divn,
    input  logic          load,
    input  logic [CW-1:0] start_val,
    input  logic [CW-1:0] cmp_val,
    input  logic          clr_mat,
    output logic [CW-1:0] cnt,
    output logic          mat
);

    localparam logic [CW-1:0] TOP  = '1;
    localparam logic [CW-1:0] ZERO = '0;
    localparam logic [CW-1:0] ONE  = CW'(1);

    step_e         step;
    logic [CW-1:0] nxt;
    logic          upd;

    always_comb begin
        if (load)
            step = STEP_LOAD;
        else if (!cnt_en)
            step = STEP_IDLE;
        else if (count_up)
            step = (divn && cnt == TOP) ? STEP_RELOAD : STEP_INC;
        else
            step = (divn && cnt == ZERO) ? STEP_RELOAD : STEP_DEC;
    end

    always_comb begin
        nxt = cnt;
        upd = 1'b1;
        unique case (step)
            STEP_IDLE:   upd = 1'b0;
            STEP_LOAD:   nxt = start_val;
            STEP_RELOAD: nxt = start_val;
            STEP_INC:    nxt = cnt + ONE;
            STEP_DEC:    nxt = cnt - ONE;
            default:     upd = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            mat <= 1'b0;
        end else begin
            cnt <= nxt;
            mat <= (upd && (nxt == cmp_val)) || (mat && !clr_mat);
        end
    end

    // R4: a load wins over counting and lands on the next cycle
    a_r4_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(start_val)));

    // R3: with no enable and no load the count holds
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !load) |=> $stable(cnt));

    // R6: carry in divide-by-N brings the start value, not zero
    a_r6_carry_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (divn && cnt_en && count_up && !load && cnt == TOP) |=> (cnt == $past(start_val)));

    // R6: borrow in divide-by-N brings the start value, not all ones
    a_r6_borrow_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (divn && cnt_en && !count_up && !load && cnt == ZERO) |=> (cnt == $past(start_val)));

    // R7: a new match flag only appears together with a count equal to the compare value
    a_r7_match_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mat) |-> (cnt == $past(cmp_val)));

endmodule

// File: rtl/cntch_hold.sv
module cntch_hold
    import cntch_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic          rel_req,
    input  logic          clr_ovfl,
    input  logic [CW-1:0] cnt,
    output logic          held,
    output logic [CW-1:0] snap,
    output logic          ovfl
);

    hold_e state;
    hold_e state_n;

    always_comb begin
        state_n = state;
        unique case (state)
            HOLD_IDLE: state_n = capture ? HOLD_BUSY : HOLD_IDLE;
            HOLD_BUSY: state_n = rel_req ? HOLD_IDLE : HOLD_BUSY;
            default:   state_n = HOLD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= HOLD_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap <= '0;
            ovfl <= 1'b0;
        end else begin
            if (state == HOLD_IDLE && capture) snap <= cnt;
            ovfl <= (state == HOLD_BUSY && capture) || (ovfl && !clr_ovfl);
        end
    end

    assign held = (state == HOLD_BUSY);

    // R9: a capture from idle freezes the current count and enters hold
    a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (state == HOLD_IDLE && capture) |=> (held && snap == $past(cnt)));

    // R11: a capture during hold is lost and flagged
    a_r11_lost_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (state == HOLD_BUSY && capture) |=> (ovfl && $stable(snap)));

    // R10: without a release the hold persists
    a_r10_hold_persists: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !rel_req) |=> (held && $stable(snap)));

endmodule

// File: rtl/counter_channel.sv
module counter_channel
    import cntch_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_en,
    input  logic        bus_wr,
    input  logic [11:0] bus_addr,
    input  logic [3:0]  bus_be,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        cnt_en,
    input  logic        count_up,
    input  logic        ctl_in,
    output logic        irq
);

    logic [CW-1:0] start_q;
    logic [CW-1:0] cmp_q;
    logic [CW-1:0] cnt;
    logic [CW-1:0] snap;
    mode_e         mode_q;
    logic          ie_q;
    logic          cmd_load;
    logic          cmd_cap;
    logic          clr_mat;
    logic          clr_ovfl;
    logic          rel_req;
    logic          held;
    logic          mat;
    logic          ovfl;
    logic          ctl_q;
    logic          ctl_rise;
    logic          load;
    logic          capture;
    logic          divn;

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= 1'b0;
        else        ctl_q <= ctl_in;
    end

    assign ctl_rise = ctl_in && !ctl_q;
    assign load     = cmd_load || (mode_q == MODE_LOADCTL && ctl_rise);
    assign capture  = cmd_cap  || (mode_q == MODE_CAPCTL  && ctl_rise);
    assign divn     = (mode_q == MODE_DIVN);
    assign irq      = mat && ie_q;

    cntch_regs #(.CW(CW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt_val   (cnt),
        .snap_val  (snap),
        .held      (held),
        .mat       (mat),
        .ovfl      (ovfl),
        .start_q   (start_q),
        .cmp_q     (cmp_q),
        .mode_q    (mode_q),
        .ie_q      (ie_q),
        .cmd_load  (cmd_load),
        .cmd_cap   (cmd_cap),
        .clr_mat   (clr_mat),
        .clr_ovfl  (clr_ovfl),
        .rel_req   (rel_req)
    );

    cntch_core #(.CW(CW)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_en    (cnt_en),
        .count_up  (count_up),
        .divn      (divn),
        .load      (load),
        .start_val (start_q),
        .cmp_val   (cmp_q),
        .clr_mat   (clr_mat),
        .cnt       (cnt),
        .mat       (mat)
    );

    cntch_hold #(.CW(CW)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .rel_req  (rel_req),
        .clr_ovfl (clr_ovfl),
        .cnt      (cnt),
        .held     (held),
        .snap     (snap),
        .ovfl     (ovfl)
    );

    // R5: outside load-on-control mode a control edge alone does not move an idle counter
    a_r5_ctl_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rise && mode_q != MODE_LOADCTL && !cmd_load && !cnt_en) |=> $stable(cnt));

endmodule

// File: tb/counter_channel_test.sv
module counter_channel_test;

    localparam int CW  = 8;
    localparam int MOD = 1 << CW;

    localparam logic [11:0] A_START = 12'h120;
    localparam logic [11:0] A_CMP   = 12'h124;
    localparam logic [11:0] A_SNAP  = 12'h128;
    localparam logic [11:0] A_MODE  = 12'h12C;
    localparam logic [11:0] A_CMD   = 12'h130;
    localparam logic [11:0] A_STAT  = 12'h134;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cnt_en = 1'b0;
    logic        count_up = 1'b1;
    logic        ctl_in = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    counter_channel #(.CW(CW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt_en    (cnt_en),
        .count_up  (count_up),
        .ctl_in    (ctl_in),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // all tasks are entered and left at a falling edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d, input logic [3:0] be = 4'hF);
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_be = be;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0; bus_be = '0;
    endtask

    task automatic run(input int n, input logic up);
        count_up = up;
        cnt_en = 1'b1;
        repeat (n) @(negedge clk);
        cnt_en = 1'b0;
    endtask

    task automatic pulse();
        ctl_in = 1'b1;
        @(negedge clk);
        ctl_in = 1'b0;
        @(negedge clk);
    endtask

    task automatic load_cnt(input int v);
        wr(A_START, 32'(v));
        wr(A_CMD, 32'h10);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        int pv[5] = '{0, 1, 127, 254, 255};
        int kv[3] = '{1, 3, 200};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state, R1 command register reads 0
        rd(A_START, d); chk("R2 start", d, 32'h0);
        rd(A_CMP, d);   chk("R2 compare", d, 32'hFF);
        rd(A_SNAP, d);  chk("R2 snapshot", d, 32'h0);
        rd(A_MODE, d);  chk("R2 mode", d, 32'h0);
        rd(A_STAT, d);  chk("R2 status", d, 32'h0);
        chk("R2 irq", 32'(irq), 32'h0);
        rd(A_CMD, d);   chk("R1 cmd reads zero", d, 32'h0);
        rd(12'h138, d); chk("R1 unmapped", d, 32'h0);

        // R3 free-run up and down with wrap
        foreach (pv[i]) begin
            foreach (kv[j]) begin
                load_cnt(pv[i]);
                run(kv[j], 1'b1);
                rd(A_SNAP, d);
                chk("R3 up", d, 32'((pv[i] + kv[j]) % MOD));
                load_cnt(pv[i]);
                run(kv[j], 1'b0);
                rd(A_SNAP, d);
                chk("R3 down", d, 32'((pv[i] - kv[j] + MOD) % MOD));
            end
        end

        // R6 divide-by-N reload on carry and borrow
        wr(A_MODE, 32'h2);
        foreach (pv[i]) begin
            foreach (kv[j]) begin
                load_cnt(pv[i]);
                run(kv[j], 1'b1);
                rd(A_SNAP, d);
                chk("R6 carry", d, 32'(pv[i] + (kv[j] % (MOD - pv[i]))));
                load_cnt(pv[i]);
                run(kv[j], 1'b0);
                rd(A_SNAP, d);
                chk("R6 borrow", d, 32'(pv[i] - (kv[j] % (pv[i] + 1))));
            end
        end
        wr(A_MODE, 32'h0);

        // R4 load has priority over counting
        wr(A_START, 32'h80);
        count_up = 1'b1;
        cnt_en = 1'b1;
        wr(A_CMD, 32'h10);
        cnt_en = 1'b0;
        rd(A_SNAP, d); chk("R4 load priority", d, 32'h80);

        // R7 match set on arrival, sticky, cleared by writing 1; R8 irq
        wr(A_STAT, 32'h64);
        wr(A_CMP, 32'h40);
        wr(A_MODE, 32'h8);
        load_cnt(32'h3D);
        rd(A_STAT, d); chk("R7 no early match", d, 32'h0);
        run(3, 1'b1);
        rd(A_STAT, d); chk("R7 match set", d, 32'h4);
        chk("R8 irq high", 32'(irq), 32'h1);
        wr(A_STAT, 32'h4);
        rd(A_STAT, d); chk("R7 match cleared", d, 32'h0);
        chk("R8 irq low after clear", 32'(irq), 32'h0);
        repeat (5) @(negedge clk);
        rd(A_STAT, d); chk("R7 no reset while equal", d, 32'h0);
        wr(A_MODE, 32'h0);
        load_cnt(32'h40);
        rd(A_STAT, d); chk("R7 match by load", d, 32'h4);
        chk("R8 irq masked", 32'(irq), 32'h0);
        wr(A_STAT, 32'h4);

        // R9 capture, R11 lost capture, R10 release by read
        load_cnt(32'h10);
        wr(A_CMD, 32'h40);
        rd(A_STAT, d); chk("R9 hold active", d, 32'h20);
        run(5, 1'b1);
        wr(A_CMD, 32'h40);
        rd(A_STAT, d); chk("R11 overflow set", d, 32'h60);
        rd(A_SNAP, d); chk("R9 R11 snapshot kept", d, 32'h10);
        rd(A_STAT, d); chk("R10 read releases", d, 32'h40);
        rd(A_SNAP, d); chk("R9 live after release", d, 32'h15);
        wr(A_STAT, 32'h40);
        rd(A_STAT, d); chk("R11 overflow cleared", d, 32'h0);

        // R9 capture on control edge; R12 partial read; R10 release by write
        wr(A_MODE, 32'h3);
        pulse();
        run(2, 1'b1);
        rd(A_SNAP, d, 4'h3); chk("R12 partial read zero", d, 32'h0);
        rd(A_STAT, d); chk("R12 partial read keeps hold", d, 32'h20);
        wr(A_STAT, 32'h20);
        rd(A_STAT, d); chk("R10 release write", d, 32'h0);
        rd(A_SNAP, d); chk("R5 capture edge did not load", d, 32'h17);

        // R5 load on control edge only in load-on-control mode
        wr(A_MODE, 32'h1);
        pulse();
        rd(A_SNAP, d); chk("R5 edge loads", d, 32'h10);
        wr(A_START, 32'h33);
        wr(A_MODE, 32'h0);
        pulse();
        rd(A_SNAP, d); chk("R5 edge ignored in free mode", d, 32'h10);

        // R12 partial writes have no effect
        wr(A_START, 32'hAA, 4'h1);
        rd(A_START, d); chk("R12 partial write", d, 32'h33);
        wr(A_CMD, 32'h10, 4'h7);
        rd(A_SNAP, d); chk("R12 partial command", d, 32'h10);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule